// File: doc/BRIEF.md
# Bank Page Close Policy Controller

This block decides, for every DRAM bank, whether an open row is kept open after a read or write and how it is closed when it is not. It sits beside the command scheduler. Each cycle it sees the issued command (bank, direction, priority, scrub marker), the activates and precharges that went to the banks, and a per-bank flag from the command queue saying whether further page hits to that bank are still waiting.

With the page-close policy on and the close timer at zero, a bank stays open only while queued hits to it remain. The last hit goes out with an auto-precharge flag. Two cases get an explicit precharge request instead: scrub traffic, and a command whose class differs from the previous issued command. The classes are low-priority read, high-priority read and write. With the policy off, the bank stays open until the surrounding controller closes it. With a non-zero timer, auto-precharge is withheld and closing is left to an external timer path. The policy and timer values are held in a small register loaded by a configuration strobe. The register comes out of reset with page-close on and the timer at zero.

Each bank runs a three-state machine. The states are CLOSED (no row open), OPEN (row open), and CLOSE_REQ (row open, explicit precharge requested). The transitions are:
- activate: CLOSED→OPEN and CLOSE_REQ→OPEN.
- close event: any state→CLOSED.
- auto-close: OPEN→CLOSED, on the last hit issued with auto-precharge.
- exception-close: OPEN→CLOSE_REQ, on the last hit when the command is scrub traffic or starts a new class.
- rehit: CLOSE_REQ→OPEN, when queued hits reappear before the close event.

Top module: `pcp_policy_ctrl`

## Requirements
- R1: After reset every bank is CLOSED, no precharge request is raised, and the policy register holds page-close on with timer 0, even when `cfg_pclose_en` is low and `cfg_wr` has not been pulsed.
- R2: With page-close on and timer 0, a non-scrub command of the same class as the previous command, to an OPEN bank with `hits_left` low for that bank, drives `cmd_autopre` high in its cycle, and the bank is CLOSED after the edge.
- R3: If `hits_left` is high for the commanded bank, `cmd_autopre` is low and the bank stays OPEN with no request.
- R4: A scrub command that would otherwise be the last hit gets `cmd_autopre` low and moves the bank to CLOSE_REQ (`pre_req` high, `bank_is_open` high).
- R5: Classes are write (any `cmd_hi_pri`), read with `cmd_hi_pri`=0, and read with `cmd_hi_pri`=1. When the class differs from the previous issued command (to any bank), a command that would otherwise be the last hit gets `cmd_autopre` low and moves the bank to CLOSE_REQ. The first command after reset never counts as a switch.
- R6: With a non-zero timer in the policy register, `cmd_autopre` stays low, and the bank stays OPEN with no request.
- R7: With page-close off, `cmd_autopre` stays low and no request is raised, even for scrub traffic. The bank stays OPEN until a close event.
- R8: `pre_req` for a bank stays high until a close event (`pre_valid` with that bank), after which the bank is CLOSED.
- R9: If `hits_left` rises for a bank in CLOSE_REQ before its close event, `pre_req` drops and the bank returns to OPEN.
- R10: A command to a CLOSED bank never sets `cmd_autopre` and leaves the bank CLOSED.
- R11: An activate opens a CLOSED bank. A close event to the same bank in the same cycle wins, and the bank ends CLOSED.
- R12: A `cfg_wr` pulse loads `cfg_pclose_en` and `cfg_close_timer` into the policy register. A command in the same cycle still sees the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads the policy register |
| cfg_pclose_en | input | 1 | Page-close policy value to load |
| cfg_close_timer | input | TMR_W | Close timer value to load (0 selects auto-precharge) |
| cmd_valid | input | 1 | A read or write is issued this cycle |
| cmd_bank | input | BANK_W | Bank of the issued command |
| cmd_is_wr | input | 1 | Issued command is a write |
| cmd_hi_pri | input | 1 | Issued read is high priority (ignored for writes) |
| cmd_scrub | input | 1 | Issued command belongs to ECC scrub |
| hits_left | input | NB | Per bank: page hits still queued apart from the issued command |
| act_valid | input | 1 | Activate issued this cycle |
| act_bank | input | BANK_W | Bank of the activate |
| pre_valid | input | 1 | Bank closed this cycle (precharge, refresh or row miss) |
| pre_bank | input | BANK_W | Bank of the close event |
| cmd_autopre | output | 1 | Issue the current command with auto-precharge |
| pre_req | output | NB | Per bank: explicit precharge requested |
| bank_is_open | output | NB | Per bank: a row is open |

## Verification
The bench works through the three ways the last hit can leave the bank: auto-close, exception-close through scrub, and exception-close through each kind of class switch. It compares these against the cases that must keep the row open: hits still queued, a non-zero timer, and policy off. A design that ignored the class history would precharge automatically after a read/write turnaround. A design that missed the scrub gate would auto-close on scrub traffic. The bench also holds a request for several cycles and then withdraws it with a fresh hit, which catches a request that drops early or that sticks after the bank is reused. Finally it checks the reset value of the policy register and the one-cycle latency of a configuration write, and confirms that a close event beats an activate in the same cycle.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    typedef enum logic [1:0] {
        BK_CLOSED    = 2'd0,
        BK_OPEN      = 2'd1,
        BK_CLOSE_REQ = 2'd2
    } bank_st_e;

    typedef enum logic [1:0] {
        CLS_RD_LO = 2'd0,
        CLS_RD_HI = 2'd1,
        CLS_WR    = 2'd2
    } cmd_cls_e;

    function automatic cmd_cls_e cls_of(input logic is_wr, input logic hi_pri);
        if (is_wr)
            return CLS_WR;
        return hi_pri ? CLS_RD_HI : CLS_RD_LO;
    endfunction

endpackage

// File: rtl/pcp_policy_reg.sv
module pcp_policy_reg #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_pclose_en,
    input  logic [TMR_W-1:0] cfg_close_timer,
    output logic             pclose_on,
    output logic             timer_zero
);
    logic             pclose_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclose_q <= 1'b1;
            tmr_q    <= '0;
        end else if (cfg_wr) begin
            pclose_q <= cfg_pclose_en;
            tmr_q    <= cfg_close_timer;
        end
    end

    assign pclose_on  = pclose_q;
    assign timer_zero = (tmr_q == '0);

    // a configuration write takes effect exactly one cycle later
    p_cfg_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (pclose_on == $past(cfg_pclose_en)));
endmodule

// File: rtl/pcp_class_track.sv
module pcp_class_track
    import pcp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  cmd_cls_e cmd_cls,
    output logic     cls_switch
);
    cmd_cls_e last_q;
    logic     seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CLS_RD_LO;
            seen_q <= 1'b0;
        end else if (cmd_valid) begin
            last_q <= cmd_cls;
            seen_q <= 1'b1;
        end
    end

    assign cls_switch = cmd_valid && seen_q && (cmd_cls != last_q);

    // a switch is only ever reported alongside an issued command
    p_switch_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cls_switch |-> cmd_valid);
endmodule

// File: rtl/pcp_bank_fsm.sv
module pcp_bank_fsm
    import pcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic close_ev,
    input  logic open_ev,
    input  logic cmd_hit,
    input  logic cmd_scrub,
    input  logic cls_switch,
    input  logic pclose_on,
    input  logic timer_zero,
    input  logic hits_left,
    output logic ap_flag,
    output logic pre_req,
    output logic is_open
);
    bank_st_e st_q, st_d;
    logic     last_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BK_CLOSED;
        else        st_q <= st_d;
    end

    always_comb begin
        last_hit = cmd_hit && !close_ev && !open_ev && (st_q == BK_OPEN)
                   && !hits_left && pclose_on && timer_zero;
        ap_flag  = last_hit && !cmd_scrub && !cls_switch;
        st_d     = st_q;
        unique case (st_q)
            BK_CLOSED: begin
                if (open_ev && !close_ev) st_d = BK_OPEN;
            end
            BK_OPEN: begin
                if (close_ev)      st_d = BK_CLOSED;
                else if (ap_flag)  st_d = BK_CLOSED;
                else if (last_hit) st_d = BK_CLOSE_REQ;
            end
            BK_CLOSE_REQ: begin
                if (close_ev)                  st_d = BK_CLOSED;
                else if (open_ev || hits_left) st_d = BK_OPEN;
            end
            default: st_d = BK_CLOSED;
        endcase
    end

    always_comb begin
        pre_req = (st_q == BK_CLOSE_REQ);
        is_open = (st_q != BK_CLOSED);
    end

    p_ap_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ap_flag |=> !is_open);
    p_ap_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ap_flag |-> is_open);
    p_off_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pclose_on && !pre_req) |=> !pre_req);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req && !close_ev && !open_ev && !hits_left) |=> pre_req);
    p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req && hits_left && !close_ev) |=> (!pre_req && is_open));
    p_close_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        close_ev |=> !is_open);
endmodule

// File: rtl/pcp_policy_ctrl.sv
module pcp_policy_ctrl
    import pcp_pkg::*;
#(
    parameter int NB     = 8,
    parameter int TMR_W  = 8,
    parameter int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_pclose_en,
    input  logic [TMR_W-1:0]  cfg_close_timer,
    input  logic              cmd_valid,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_is_wr,
    input  logic              cmd_hi_pri,
    input  logic              cmd_scrub,
    input  logic [NB-1:0]     hits_left,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              pre_valid,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              cmd_autopre,
    output logic [NB-1:0]     pre_req,
    output logic [NB-1:0]     bank_is_open
);
    logic          pclose_on;
    logic          timer_zero;
    logic          cls_switch;
    logic [NB-1:0] ap_vec;

    pcp_policy_reg #(.TMR_W(TMR_W)) u_pol (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr         (cfg_wr),
        .cfg_pclose_en  (cfg_pclose_en),
        .cfg_close_timer(cfg_close_timer),
        .pclose_on      (pclose_on),
        .timer_zero     (timer_zero)
    );

    pcp_class_track u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_cls   (cls_of(cmd_is_wr, cmd_hi_pri)),
        .cls_switch(cls_switch)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        pcp_bank_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .close_ev  (pre_valid && (pre_bank == BANK_W'(b))),
            .open_ev   (act_valid && (act_bank == BANK_W'(b))),
            .cmd_hit   (cmd_valid && (cmd_bank == BANK_W'(b))),
            .cmd_scrub (cmd_scrub),
            .cls_switch(cls_switch),
            .pclose_on (pclose_on),
            .timer_zero(timer_zero),
            .hits_left (hits_left[b]),
            .ap_flag   (ap_vec[b]),
            .pre_req   (pre_req[b]),
            .is_open   (bank_is_open[b])
        );
    end

    assign cmd_autopre = |ap_vec;

    p_scrub_no_ap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_scrub) |-> !cmd_autopre);
    p_timer_no_ap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_zero |-> !cmd_autopre);
    p_ap_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_autopre |-> (cmd_valid && pclose_on));
endmodule

// File: tb/tb_pcp_policy_ctrl.sv
`timescale 1ns/1ps
module tb_pcp_policy_ctrl;
    localparam int NB = 8;
    localparam int TW = 8;
    localparam int BW = 3;
    localparam int NV = 11;

    // [10]pclose [9]timer!=0 [8]prev wr [7]prev hi [6]wr [5]hi [4]scrub [3]hits
    // [2]exp autopre [1]exp open after [0]exp request after
    localparam logic [10:0] VEC [NV] = '{
        11'b10000000100,  // R2 read, same class
        11'b10101000100,  // R2 write, same class
        11'b10000001010,  // R3 hits remain
        11'b10000010011,  // R4 scrub
        11'b10100000011,  // R5 write to low read
        11'b10000100011,  // R5 low read to high read
        11'b10001000011,  // R5 read to write
        11'b11000000010,  // R6 timer non-zero
        11'b00000000010,  // R7 policy off
        11'b00000010010,  // R7 policy off, scrub
        11'b10010100100   // R5 high read to high read is no switch
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_wr, cfg_pclose_en;
    logic [TW-1:0] cfg_close_timer;
    logic cmd_valid, cmd_is_wr, cmd_hi_pri, cmd_scrub;
    logic [BW-1:0] cmd_bank, act_bank, pre_bank;
    logic [NB-1:0] hits_left;
    logic act_valid, pre_valid;
    logic cmd_autopre;
    logic [NB-1:0] pre_req, bank_is_open;
    int checks = 0;
    int errors = 0;
    logic [10:0] v;

    always #4 clk = ~clk;

    pcp_policy_ctrl #(.NB(NB), .TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pclose_en(cfg_pclose_en),
        .cfg_close_timer(cfg_close_timer), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
        .cmd_is_wr(cmd_is_wr), .cmd_hi_pri(cmd_hi_pri), .cmd_scrub(cmd_scrub),
        .hits_left(hits_left), .act_valid(act_valid), .act_bank(act_bank),
        .pre_valid(pre_valid), .pre_bank(pre_bank), .cmd_autopre(cmd_autopre),
        .pre_req(pre_req), .bank_is_open(bank_is_open)
    );

    function automatic string vreq(input int i);
        case (i)
            0, 1: return "R2";
            2: return "R3";
            3: return "R4";
            7: return "R6";
            8, 9: return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_wr = 1'b0; cmd_valid = 1'b0; cmd_scrub = 1'b0;
        act_valid = 1'b0; pre_valid = 1'b0; hits_left = '0;
    endtask

    task automatic open_bank(input logic [BW-1:0] b);
        act_valid = 1'b1; act_bank = b; tick(); idle();
    endtask

    task automatic cmd(input logic [BW-1:0] b, input logic w, input logic h, input logic s);
        cmd_valid = 1'b1; cmd_bank = b; cmd_is_wr = w; cmd_hi_pri = h; cmd_scrub = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_pclose_en = 1'b0; cfg_close_timer = '0;
        cmd_bank = '0; act_bank = '0; pre_bank = '0; cmd_is_wr = 1'b0; cmd_hi_pri = 1'b0;
        idle();
        repeat (3) tick();
        chk("R1", "pre_req at reset", pre_req, '0);
        chk("R1", "bank_is_open at reset", bank_is_open, '0);
        rst_n = 1'b1;

        // R1: policy is on from reset although cfg_pclose_en is low and never written
        open_bank(0);
        chk("R11", "activate opens", bank_is_open, 8'h01);
        cmd(0, 1'b0, 1'b0, 1'b0); #1;
        chk("R1", "autopre with reset policy", cmd_autopre, 1);
        tick(); idle();
        chk("R2", "bank closed after autopre", bank_is_open, '0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            cfg_wr = 1'b1; cfg_pclose_en = v[10]; cfg_close_timer = v[9] ? 8'd5 : 8'd0;
            pre_valid = 1'b1; pre_bank = 0;
            tick(); idle();
            open_bank(0);
            cmd(1, v[8], v[7], 1'b0);
            tick(); idle();
            cmd(0, v[6], v[5], v[4]); hits_left[0] = v[3]; #1;
            chk(vreq(i), $sformatf("vector %0d autopre", i), cmd_autopre, v[2]);
            tick(); idle();
            chk(vreq(i), $sformatf("vector %0d open", i), bank_is_open[0], v[1]);
            chk(vreq(i), $sformatf("vector %0d request", i), pre_req[0], v[0]);
        end

        // restore policy on, timer 0; close bank 0
        cfg_wr = 1'b1; cfg_pclose_en = 1'b1; cfg_close_timer = '0;
        pre_valid = 1'b1; pre_bank = 0;
        tick(); idle();

        // R8: request holds until the close event
        open_bank(2);
        cmd(2, 1'b0, 1'b0, 1'b1); tick(); idle();
        repeat (3) tick();
        chk("R8", "request held", pre_req, 8'h04);
        pre_valid = 1'b1; pre_bank = 2; tick(); idle();
        chk("R8", "request cleared by close", pre_req, '0);
        chk("R8", "bank closed by close", bank_is_open, '0);

        // R9: new hit withdraws the request
        open_bank(3);
        cmd(3, 1'b0, 1'b0, 1'b1); tick(); idle();
        chk("R9", "request raised", pre_req, 8'h08);
        hits_left[3] = 1'b1; tick(); idle();
        chk("R9", "request withdrawn", pre_req, '0);
        chk("R9", "bank open again", bank_is_open, 8'h08);
        pre_valid = 1'b1; pre_bank = 3; tick(); idle();

        // R10: command to a closed bank
        cmd(4, 1'b0, 1'b0, 1'b0); #1;
        chk("R10", "no autopre on closed bank", cmd_autopre, 0);
        tick(); idle();
        chk("R10", "closed bank stays closed", bank_is_open, '0);

        // R11: close beats activate in the same cycle
        act_valid = 1'b1; act_bank = 5; pre_valid = 1'b1; pre_bank = 5;
        tick(); idle();
        chk("R11", "close wins over activate", bank_is_open, '0);

        // R12: configuration write takes effect one cycle later
        open_bank(6);
        cfg_wr = 1'b1; cfg_pclose_en = 1'b0; cmd(6, 1'b0, 1'b0, 1'b0); #1;
        chk("R12", "old policy in write cycle", cmd_autopre, 1);
        tick(); idle();
        open_bank(6);
        cmd(6, 1'b0, 1'b0, 1'b0); #1;
        chk("R12", "new policy after write", cmd_autopre, 0);
        tick(); idle();
        chk("R12", "bank stays open under new policy", bank_is_open, 8'h40);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule